// File: doc/BRIEF.md
# Multiplexed LCD Frame Waveform Sequencer

This block decides, clock by clock, which of four drive levels each common and segment pin of a passive multiplexed LCD carries under a 1/3-bias scheme. The levels are ground, one third, two thirds and full supply. The 2-bit level code is numerically 0, 1, 2, 3 in that order. An analog stage outside the block turns each code into a voltage. The block supports two scan depths: four commons, or three commons. In the three-common mode the fourth common pin becomes one extra segment pin.

A frame is split into equal slots, one slot for each active common. A 3-bit rate code sets the frame length in base clocks. A slow-clock mode divides every frame length by eight, for use with a base clock that is eight times slower. The drive polarity inverts on every frame so that the panel sees no net DC. A frame-phase output shows the current polarity.

The rate code, the slow-clock mode and the scan depth are sampled only at a frame boundary. The display bits and the blank flag act on the outputs at once. The block needs `NUM_SEG` of at least 3. The display bus holds `4*NUM_SEG` bits, and bit 0 is the first display bit.

Top module: `lcdseq_top`

## Requirements
- R1: While reset is held, and in the first cycles after it, the polarity is 0, slot 0 is selected, COM0 carries code 3 and COM1 to COM3 carry code 1.
- R2: With slow mode off and four commons, a frame lasts this many clocks: rate code 0 gives 6144, 1 gives 4608, 2 gives 3072, 3 gives 2304, 4 gives 1536, 5 gives 1152 and 6 gives 768. Each of the four slots lasts one quarter of the frame.
- R3: Rate code 7 produces exactly the same frame length as rate code 2, in both the normal mode and the slow mode.
- R4: With slow mode on, every frame length is the normal value divided by 8: 768, 576, 384, 288, 192, 144 and 96.
- R5: With three commons selected, a frame has three equal slots and the same total length as in four-common mode. The COM3 pin then drives segment levels for display bits 3·NUM_SEG to 3·NUM_SEG+2.
- R6: In four-common mode, segment n (0-based) shows display bit 4n+k during the slot of common k.
- R7: In three-common mode, segment n shows display bit 3n+k during the slot of common k.
- R8: At polarity 0 the selected common carries code 3 and every other active common carries code 1. At polarity 1 the selected common carries code 0 and every other active common carries code 2.
- R9: A segment whose bit is 1 carries the level opposite to the selected common: code 0 at polarity 0 and code 3 at polarity 1. A segment whose bit is 0 carries code 2 at polarity 0 and code 1 at polarity 1.
- R10: The polarity, and with it frame_phase, inverts at every frame boundary and at no other time.
- R11: While seg_blank is 1, every segment carries its off level from R9 whatever its display bit is. The commons keep scanning with unchanged frame timing.
- R12: A change to the rate code, the slow mode or the scan depth takes effect only from the next frame boundary. The frame in progress finishes with its old length.
- R13: After reset the block runs with rate code 0, slow mode off and four commons until the first frame boundary, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_code | input | 3 | Frame-length select, sampled at a frame boundary |
| slow_clk_mode | input | 1 | 1 = frame lengths divided by 8, sampled at a frame boundary |
| three_com | input | 1 | 1 = three commons and COM3 used as a segment, sampled at a frame boundary |
| seg_blank | input | 1 | 1 = all segments forced to their off level |
| disp_bits | input | 4*NUM_SEG | Display bits, bit 0 first |
| com_lvl | output | 8 | Level codes for COM0 to COM3, two bits each, COM0 in bits 1:0 |
| seg_lvl | output | 2*NUM_SEG | Level codes for the segments, two bits each, segment 0 in bits 1:0 |
| frame_phase | output | 1 | Current drive polarity |

## Verification
A behavioural model in the bench follows the slot counter, the polarity and the boundary-sampled settings, and predicts every pin on every clock. The frame length is measured between phase toggles for all eight rate codes in both normal and slow mode. This separates the divisor table, the alias code and the divide-by-eight path. The display bits are changed between frames, using all-zero, all-one and irregular patterns. In both scan depths this exposes a wrong bit stride, a wrong common order or a wrong polarity. Settings are also changed right after a boundary, and one measurement is taken straight after reset. These two cases show whether the new settings wait for the next boundary, and whether the reset defaults hold until then. The blanked frames check that the segments stay at their off levels while the commons keep their timing.

// File: rtl/lcdseq_pkg.sv
package lcdseq_pkg;

  typedef enum logic [1:0] {
    LV_GND      = 2'd0,
    LV_THIRD    = 2'd1,
    LV_TWOTHIRD = 2'd2,
    LV_FULL     = 2'd3
  } lvl_e;

  typedef struct packed {
    logic [2:0] code;
    logic       slow;
    logic       three;
  } cfg_t;

  // frame length in units of (divider unit); code 7 aliases code 2
  function automatic logic [6:0] rate_mult(input logic [2:0] code);
    logic [6:0] m;
    case (code)
      3'd0:    m = 7'd64;
      3'd1:    m = 7'd48;
      3'd2:    m = 7'd32;
      3'd3:    m = 7'd24;
      3'd4:    m = 7'd16;
      3'd5:    m = 7'd12;
      3'd6:    m = 7'd8;
      default: m = 7'd32;
    endcase
    return m;
  endfunction

  function automatic logic [1:0] com_level(input logic sel, input logic pol);
    lvl_e l;
    if (sel) l = pol ? LV_GND : LV_FULL;
    else     l = pol ? LV_TWOTHIRD : LV_THIRD;
    return l;
  endfunction

  function automatic logic [1:0] seg_level(input logic on, input logic pol);
    lvl_e l;
    if (on) l = pol ? LV_FULL : LV_GND;
    else    l = pol ? LV_THIRD : LV_TWOTHIRD;
    return l;
  endfunction

endpackage

// File: rtl/lcdseq_timebase.sv
module lcdseq_timebase
  import lcdseq_pkg::*;
#(
  parameter int DIV_UNIT  = 96,
  parameter int LOW_SHIFT = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  cfg_t       cfg_in,
  output logic       three_q,
  output logic [1:0] slot_q,
  output logic       pol_q
);

  localparam int LOW_UNIT = DIV_UNIT >> LOW_SHIFT;
  localparam int S4N      = DIV_UNIT / 4;
  localparam int S3N      = DIV_UNIT / 3;
  localparam int S4L      = LOW_UNIT / 4;
  localparam int S3L      = LOW_UNIT / 3;
  localparam int MAX_SLOT = 64 * ((S3N > S4N) ? S3N : S4N);
  localparam int CNT_W    = $clog2(MAX_SLOT + 1);

  cfg_t             cfg_q, cfg_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] mult_w, per_w, slot_len;
  logic [1:0]       slot_d;
  logic             pol_d;
  logic             last_cnt, last_slot, frame_wrap;

  // slot length = frame multiple * clocks per unit per common
  always_comb begin
    mult_w = CNT_W'(rate_mult(cfg_q.code));
    case ({cfg_q.slow, cfg_q.three})
      2'b00:   per_w = CNT_W'(S4N);
      2'b01:   per_w = CNT_W'(S3N);
      2'b10:   per_w = CNT_W'(S4L);
      default: per_w = CNT_W'(S3L);
    endcase
    slot_len = mult_w * per_w;
  end

  // next-state
  always_comb begin
    last_cnt   = (cnt_q == slot_len - CNT_W'(1));
    last_slot  = (slot_q == (cfg_q.three ? 2'd2 : 2'd3));
    frame_wrap = last_cnt & last_slot;
    cnt_d      = last_cnt ? '0 : cnt_q + CNT_W'(1);
    slot_d     = slot_q;
    if (last_cnt) slot_d = last_slot ? 2'd0 : slot_q + 2'd1;
    pol_d      = frame_wrap ? ~pol_q : pol_q;
    cfg_d      = frame_wrap ? cfg_in : cfg_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      slot_q <= 2'd0;
      pol_q  <= 1'b0;
      cfg_q  <= '0;
    end else begin
      cnt_q  <= cnt_d;
      slot_q <= slot_d;
      pol_q  <= pol_d;
      cfg_q  <= cfg_d;
    end
  end

  assign three_q = cfg_q.three;

  assert_slot_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.three |-> (slot_q != 2'd3));

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < slot_len);

  assert_phase_flip_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_q != $past(pol_q)) |-> (slot_q == 2'd0 && cnt_q == '0));

  assert_cfg_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_wrap |=> $stable(cfg_q));

endmodule

// File: rtl/lcdseq_seg_drv.sv
module lcdseq_seg_drv
  import lcdseq_pkg::*;
#(
  parameter int NUM_SEG = 12,
  parameter int DISP_W  = 4 * NUM_SEG
) (
  input  logic [DISP_W-1:0]    disp_bits,
  input  logic [1:0]           slot,
  input  logic                 pol,
  input  logic                 three,
  input  logic                 blank,
  output logic [2*NUM_SEG-1:0] seg_lvl,
  output logic [1:0]           extra_lvl
);

  for (genvar n = 0; n <= NUM_SEG; n++) begin : g_pin
    logic [3:0] grp3;
    assign grp3 = {1'b0, disp_bits[3*n +: 3]};
    if (n < NUM_SEG) begin : g_dual
      logic [3:0] grp4;
      logic       bit_sel;
      assign grp4    = disp_bits[4*n +: 4];
      assign bit_sel = three ? grp3[slot] : grp4[slot];
      assign seg_lvl[2*n +: 2] = seg_level(bit_sel & ~blank, pol);
    end else begin : g_extra
      assign extra_lvl = seg_level(grp3[slot] & ~blank, pol);
    end
  end

endmodule

// File: rtl/lcdseq_com_drv.sv
module lcdseq_com_drv
  import lcdseq_pkg::*;
(
  input  logic [1:0] slot,
  input  logic       pol,
  input  logic       three,
  input  logic [1:0] extra_lvl,
  output logic [7:0] com_lvl
);

  for (genvar c = 0; c < 4; c++) begin : g_com
    logic [1:0] scan;
    assign scan = com_level(slot == 2'(c), pol);
    if (c == 3) begin : g_shared
      assign com_lvl[2*c +: 2] = three ? extra_lvl : scan;
    end else begin : g_plain
      assign com_lvl[2*c +: 2] = scan;
    end
  end

endmodule

// File: rtl/lcdseq_top.sv
module lcdseq_top
  import lcdseq_pkg::*;
#(
  parameter int NUM_SEG   = 12,
  parameter int DIV_UNIT  = 96,
  parameter int LOW_SHIFT = 3,
  localparam int DISP_W   = 4 * NUM_SEG
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           rate_code,
  input  logic                 slow_clk_mode,
  input  logic                 three_com,
  input  logic                 seg_blank,
  input  logic [DISP_W-1:0]    disp_bits,
  output logic [7:0]           com_lvl,
  output logic [2*NUM_SEG-1:0] seg_lvl,
  output logic                 frame_phase
);

  cfg_t       cfg_in;
  logic       three_q;
  logic [1:0] slot_q;
  logic       pol_q;
  logic [1:0] extra_lvl;

  assign cfg_in = '{code: rate_code, slow: slow_clk_mode, three: three_com};

  lcdseq_timebase #(
    .DIV_UNIT (DIV_UNIT),
    .LOW_SHIFT(LOW_SHIFT)
  ) u_tb (
    .clk    (clk),
    .rst_n  (rst_n),
    .cfg_in (cfg_in),
    .three_q(three_q),
    .slot_q (slot_q),
    .pol_q  (pol_q)
  );

  lcdseq_seg_drv #(
    .NUM_SEG(NUM_SEG),
    .DISP_W (DISP_W)
  ) u_seg (
    .disp_bits(disp_bits),
    .slot     (slot_q),
    .pol      (pol_q),
    .three    (three_q),
    .blank    (seg_blank),
    .seg_lvl  (seg_lvl),
    .extra_lvl(extra_lvl)
  );

  lcdseq_com_drv u_com (
    .slot     (slot_q),
    .pol      (pol_q),
    .three    (three_q),
    .extra_lvl(extra_lvl),
    .com_lvl  (com_lvl)
  );

  assign frame_phase = pol_q;

  // checker terms taken from the output pins
  logic [3:0] com_ext;
  logic       seg_all_mid;
  always_comb begin
    for (int c = 0; c < 4; c++) begin
      com_ext[c] = (com_lvl[2*c +: 2] == 2'd0 || com_lvl[2*c +: 2] == 2'd3)
                   && !(c == 3 && three_q);
    end
    seg_all_mid = 1'b1;
    for (int n = 0; n < NUM_SEG; n++) begin
      if (seg_lvl[2*n +: 2] == 2'd0 || seg_lvl[2*n +: 2] == 2'd3) seg_all_mid = 1'b0;
    end
  end

  assert_one_selected_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(com_ext) == 1);

  assert_blank_mid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    seg_blank |-> seg_all_mid);

endmodule

// File: tb/sim_lcdseq_top.sv
module sim_lcdseq_top;

  localparam int NS = 12;
  localparam int DW = 4 * NS;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    rate_code;
  logic          slow_clk_mode, three_com, seg_blank;
  logic [DW-1:0] disp_bits;
  wire  [7:0]    com_lvl;
  wire  [2*NS-1:0] seg_lvl;
  wire           frame_phase;

  int checks = 0;
  int errors = 0;
  bit cmp_on = 1'b0;
  bit done   = 1'b0;

  // reference state
  int m_cnt = 0, m_slot = 0, m_pol = 0, m_code = 0, m_slow = 0, m_three = 0;

  always #5 clk = ~clk;

  lcdseq_top #(.NUM_SEG(NS)) u0 (
    .clk(clk), .rst_n(rst_n), .rate_code(rate_code), .slow_clk_mode(slow_clk_mode),
    .three_com(three_com), .seg_blank(seg_blank), .disp_bits(disp_bits),
    .com_lvl(com_lvl), .seg_lvl(seg_lvl), .frame_phase(frame_phase)
  );

  function automatic int mult_of(int c);
    case (c)
      0: return 64; 1: return 48; 2: return 32; 3: return 24;
      4: return 16; 5: return 12; 6: return 8;  default: return 32;
    endcase
  endfunction

  function automatic int frame_len(int c, int slow);
    return mult_of(c) * (slow != 0 ? 12 : 96);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_slot = 0; m_pol = 0; m_code = 0; m_slow = 0; m_three = 0;
    end else begin
      int ncom, slen;
      ncom = (m_three != 0) ? 3 : 4;
      slen = frame_len(m_code, m_slow) / ncom;
      if (m_cnt == slen - 1) begin
        m_cnt = 0;
        if (m_slot == ncom - 1) begin
          m_slot = 0; m_pol = 1 - m_pol;
          m_code = rate_code; m_slow = slow_clk_mode; m_three = three_com;
        end else m_slot = m_slot + 1;
      end else m_cnt = m_cnt + 1;
    end
  end

  function automatic int seg_exp(int n);
    int b;
    b = (m_three != 0) ? int'(disp_bits[3*n + m_slot]) : int'(disp_bits[4*n + m_slot]);
    if (b != 0 && !seg_blank) return (m_pol != 0) ? 3 : 0;
    return (m_pol != 0) ? 1 : 2;
  endfunction

  function automatic int com_exp(int c);
    if (c == m_slot) return (m_pol != 0) ? 0 : 3;
    return (m_pol != 0) ? 2 : 1;
  endfunction

  task automatic check(input int act, input int exp, input string tag, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cmp_on && !done) begin
      for (int c = 0; c < 4; c++) begin
        if (c == 3 && m_three != 0) check(int'(com_lvl[6 +: 2]), seg_exp(NS), "R5", "com3 as segment");
        else check(int'(com_lvl[2*c +: 2]), com_exp(c), "R8", "common level");
      end
      for (int n = 0; n < NS; n++) begin
        check(int'(seg_lvl[2*n +: 2]), seg_exp(n),
              seg_blank ? "R11" : ((m_three != 0) ? "R7" : "R6"), "segment level");
      end
      check(int'(frame_phase), m_pol, "R10", "frame phase");
      if (!seg_blank) check(int'(seg_lvl[1:0]), seg_exp(0), "R9", "segment 0 polarity");
    end
  end

  task automatic measure_frame(output int n);
    logic prev;
    n = 0;
    prev = frame_phase;
    do begin
      @(negedge clk);
      n++;
    end while (frame_phase == prev);
  endtask

  task automatic wait_toggle();
    int dummy;
    measure_frame(dummy);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int len;
    rate_code = 3'd6; slow_clk_mode = 1'b1; three_com = 1'b0; seg_blank = 1'b0;
    disp_bits = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(int'(com_lvl), 8'h57, "R1", "commons in reset");
    check(int'(frame_phase), 0, "R1", "phase in reset");
    check(int'(seg_lvl), int'({NS{2'b10}}), "R1", "segments in reset");
    rst_n = 1'b1;
    cmp_on = 1'b1;
    @(negedge clk);
    check(int'(com_lvl), 8'h57, "R1", "commons after reset");
    // R13: first frame uses defaults despite other inputs
    measure_frame(len);
    check(len + 1, 6144, "R13", "first frame length");
    #1 disp_bits = 48'hA5C3_0F96_E187;
    measure_frame(len);
    check(len, 96, "R4", "slow code 6 frame");
    // slow-mode table
    for (int c = 0; c < 8; c++) begin
      #1 rate_code = 3'(c);
      disp_bits = {disp_bits[DW-8:0], disp_bits[DW-1 -: 7]} ^ DW'(c * 48'h1111_0357);
      wait_toggle();
      #1 disp_bits = (c % 2 == 0) ? '1 : ~disp_bits;
      measure_frame(len);
      check(len, mult_of(c) * 12, (c == 7) ? "R3" : "R4", "slow frame length");
    end
    // R12: change right after a boundary
    #1 rate_code = 3'd6;
    measure_frame(len);
    check(len, 384, "R12", "frame in progress keeps old length");
    measure_frame(len);
    check(len, 96, "R12", "new length after boundary");
    // three-common mode
    #1 three_com = 1'b1; disp_bits = 48'h5555_AAAA_3C3C;
    wait_toggle();
    measure_frame(len);
    check(len, 96, "R5", "three-common frame length");
    #1 rate_code = 3'd0; disp_bits = 48'hFFFF_0000_F0F1;
    wait_toggle();
    measure_frame(len);
    check(len, 768, "R7", "three-common slow code 0 frame");
    // blanking
    #1 seg_blank = 1'b1;
    @(negedge clk);
    for (int n = 0; n < NS; n++)
      check(int'(seg_lvl[2*n +: 2]), frame_phase ? 1 : 2, "R11", "blanked segment");
    wait_toggle();
    measure_frame(len);
    check(len, 768, "R11", "commons keep timing while blanked");
    #1 seg_blank = 1'b0; three_com = 1'b0; slow_clk_mode = 1'b0;
    disp_bits = 48'h0123_4567_89AB;
    // normal table
    for (int c = 6; c >= -1; c--) begin
      int cc;
      cc = (c < 0) ? 7 : c;
      #1 rate_code = 3'(cc);
      wait_toggle();
      #1 disp_bits = ~{disp_bits[DW-2:0], disp_bits[DW-1]};
      measure_frame(len);
      check(len, mult_of(cc) * 96, (cc == 7) ? "R3" : "R2", "normal frame length");
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule